// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of a 12-bit successive-approximation converter. It watches an active-low chip select and an active-low read/convert strobe. Internally the two are merged by a logical OR into one combined select. When that combined select falls, the block starts a conversion. It lowers `busy` and walks a trial word from the most significant bit down to the least significant bit. At each bit it consults a one-bit comparator answer supplied from outside. Once the last bit has been decided, it copies the final trial word into a result register and raises `busy` again.

The analog sample/hold, the capacitor array and the comparator are not part of this block. A digital comparator input `cmp_hi` stands in for them. The caller computes `cmp_hi` from the current `trial_word`. A high power-down input stops new conversions and leaves the last result untouched. If the combined select is still low at the moment a conversion completes, a new conversion is launched right away with no acquisition gap. All control inputs are resynchronized to the block clock before use. The number of clocks spent on each bit trial, and the number of clocks spent latching the result, are both parameters.

Top module: `sar_seq_ctrl`

## Requirements
- R1: A conversion starts only on a falling edge of the combined select (`cs_n` OR `rc_n`). Either `rc_n` falling while `cs_n` is low or `cs_n` falling while `rc_n` is low will do. A fall of one input while the other is high starts nothing. With 2 synchronizer stages, `busy` is first seen low 3 clock edges after the input change.
- R2: `busy` stays low for exactly RES_BITS×CYC_PER_BIT + LATCH_CYC clock cycles per conversion. With the defaults this is 12×4+1 = 49.
- R3: When `busy` rises, `result` holds the successive-approximation outcome, which is the largest code not above the comparator threshold. `result` changes in the same cycle that `busy` rises and at no other time.
- R4: If the synchronized combined select is still low when `busy` rises, `busy` stays high for exactly one cycle and a new conversion begins. If the select is high, `busy` stays high.
- R5: While `pwrdn` is high, a falling combined select starts no conversion, and `result` keeps its last value.
- R6: A falling combined select that arrives while `busy` is low is ignored. It neither lengthens nor restarts the running conversion.
- R7: Bit k (from RES_BITS-1 down to 0) is tried for CYC_PER_BIT cycles. During that time, the bits above k hold their decided values, bit k is 1, and the bits below k are 0. At the end of the trial, bit k is kept if `cmp_hi` is 1 and cleared if `cmp_hi` is 0.
- R8: After reset, `busy` is 1, `result` is 0 and `trial_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select, asynchronous |
| rc_n | input | 1 | Active-low read/convert strobe, asynchronous |
| pwrdn | input | 1 | Power-down; high inhibits conversions |
| cmp_hi | input | 1 | Comparator answer for the current trial word; 1 keeps the bit under trial |
| trial_word | output | RES_BITS | Current successive-approximation trial word |
| busy | output | 1 | Low while a conversion and its latch are in progress |
| result | output | RES_BITS | Last completed conversion result |

## Verification
Some properties are checked on every cycle by assertions. These are: the exact `busy` low length, measured by a counter; `result` changing only on a `busy` rise; power-down keeping the sequencer idle; the one-cycle restart when the select stays low; and the shape of the trial word (first trial, bit under trial set, lower bits clear). Other behaviours can only be shown by the bench's scenarios. These are: the start latency for each edge order of the two selects; a lone select edge being rejected; a request in the middle of a conversion being ignored; and the final code actually matching the comparator threshold. The bench shows the last of these by sweeping thresholds across the full code range while conversions run back to back.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONV  = 2'd1,
        ST_LATCH = 2'd2
    } sar_state_e;

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        logic [STAGES-1:0] chain_d;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], d[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
            else        chain_q <= chain_d;
        end

        assign q[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
    parameter int BITS = 12,
    parameter int CPB  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            cmp_hi,
    output logic [BITS-1:0] trial,
    output logic            fin
);

    localparam int IW = (BITS > 1) ? $clog2(BITS) : 1;
    localparam int CW = (CPB > 1) ? $clog2(CPB) : 1;
    localparam logic [CW-1:0]   CNT_LAST = CW'(CPB - 1);
    localparam logic [IW-1:0]   IDX_TOP  = IW'(BITS - 1);
    localparam logic [BITS-1:0] MSB_ONLY = {1'b1, {(BITS-1){1'b0}}};

    typedef struct packed {
        logic            run;
        logic [IW-1:0]   idx;
        logic [CW-1:0]   cnt;
        logic [BITS-1:0] trial;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d   = q;
        fin = 1'b0;
        if (start) begin
            d.run   = 1'b1;
            d.idx   = IDX_TOP;
            d.cnt   = '0;
            d.trial = MSB_ONLY;
        end else if (q.run) begin
            if (q.cnt == CNT_LAST) begin
                d.cnt = '0;
                if (!cmp_hi) d.trial[q.idx] = 1'b0;
                if (q.idx == '0) begin
                    d.run = 1'b0;
                    fin   = 1'b1;
                end else begin
                    d.idx                   = q.idx - IW'(1);
                    d.trial[q.idx - IW'(1)] = 1'b1;
                end
            end else begin
                d.cnt = q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign trial = q.trial;

    AST_FIRST_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (q.run && trial == MSB_ONLY)); // R7
    AST_TRIAL_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        q.run |-> trial[q.idx]); // R7
    AST_LOWER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        q.run |-> (((trial >> q.idx) << q.idx) == trial)); // R7

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl #(
    parameter int RES_BITS    = 12,
    parameter int CYC_PER_BIT = 4,
    parameter int LATCH_CYC   = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                rc_n,
    input  logic                pwrdn,
    input  logic                cmp_hi,
    output logic [RES_BITS-1:0] trial_word,
    output logic                busy,
    output logic [RES_BITS-1:0] result
);
    import sar_seq_pkg::*;

    localparam int LW       = (LATCH_CYC > 1) ? $clog2(LATCH_CYC) : 1;
    localparam int BUSY_LOW = RES_BITS * CYC_PER_BIT + LATCH_CYC;
    localparam int TW       = $clog2(BUSY_LOW + 2);
    localparam logic [LW-1:0] LAT_LAST = LW'(LATCH_CYC - 1);

    typedef struct packed {
        sar_state_e          st;
        logic                sel_prev;
        logic                done;
        logic [LW-1:0]       lat;
        logic [RES_BITS-1:0] res;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_IDLE, sel_prev: 1'b1, done: 1'b0,
                                 lat: '0, res: '0};

    logic [2:0] raw_in, sync_out;
    logic       cs_s, rc_s, pd_s, sel_s;
    logic       start, fin;
    ctl_t       q, d;

    assign raw_in = {pwrdn, rc_n, cs_n};

    sar_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw_in),
        .q    (sync_out)
    );

    assign cs_s  = sync_out[0];
    assign rc_s  = sync_out[1];
    assign pd_s  = sync_out[2];
    assign sel_s = cs_s | rc_s;

    sar_approx #(.BITS(RES_BITS), .CPB(CYC_PER_BIT)) u_approx (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .cmp_hi(cmp_hi),
        .trial (trial_word),
        .fin   (fin)
    );

    always_comb begin
        d          = q;
        d.sel_prev = sel_s;
        d.done     = 1'b0;
        start      = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (!pd_s && !sel_s && (q.sel_prev || q.done)) begin
                    start = 1'b1;
                    d.st  = ST_CONV;
                end
            end
            ST_CONV: begin
                if (fin) begin
                    d.st  = ST_LATCH;
                    d.lat = '0;
                end
            end
            ST_LATCH: begin
                if (q.lat == LAT_LAST) begin
                    d.st   = ST_IDLE;
                    d.res  = trial_word;
                    d.done = 1'b1;
                end else begin
                    d.lat = q.lat + LW'(1);
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CTL_RST;
        else        q <= d;
    end

    assign busy   = (q.st == ST_IDLE);
    assign result = q.res;

    logic [TW-1:0] low_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    low_cnt_q <= '0;
        else if (!busy) low_cnt_q <= low_cnt_q + TW'(1);
        else           low_cnt_q <= '0;
    end

    AST_BUSY_LOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (low_cnt_q == TW'(BUSY_LOW))); // R2
    AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(busy) |-> $stable(result)); // R3
    AST_RESTART_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(busy) && !sel_s && !pd_s) |=> !busy); // R4
    AST_PD_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pd_s) |=> busy); // R5

endmodule

// File: tb/sim_sar_seq_ctrl.sv
module sim_sar_seq_ctrl;
    localparam int BITS = 12;
    localparam int CPB  = 4;
    localparam int LAT  = 1;
    localparam int SYNC = 2;
    localparam int BUSY_LOW = BITS * CPB + LAT;

    logic            clk = 1'b0;
    logic            rst_n, cs_n, rc_n, pwrdn, cmp_hi, busy;
    logic [BITS-1:0] trial_word, result, vin;
    int              checks = 0;
    int              fails  = 0;

    always #2 clk = ~clk;

    assign cmp_hi = (trial_word <= vin);

    sar_seq_ctrl #(.RES_BITS(BITS), .CYC_PER_BIT(CPB), .LATCH_CYC(LAT),
                   .SYNC_STAGES(SYNC)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rc_n(rc_n), .pwrdn(pwrdn),
        .cmp_hi(cmp_hi), .trial_word(trial_word), .busy(busy), .result(result)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_low(output int lat);
        lat = 0;
        while (busy && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic measure_low(output int n);
        n = 0;
        while (!busy && n < BUSY_LOW + 20) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int l, n, tot, k;
        logic [BITS-1:0] exp_t;
        bit went_low;
        cs_n = 1; rc_n = 1; pwrdn = 0; vin = '0; rst_n = 0;
        repeat (5) @(negedge clk);
        chk(busy == 1'b1, "R8 busy", busy, 1);
        chk(result == '0, "R8 result", result, 0);
        chk(trial_word == '0, "R8 trial", trial_word, 0);
        rst_n = 1;
        @(negedge clk);

        // R1: cs_n alone falls while rc_n high -> nothing
        vin  = 12'hA5C;
        cs_n = 0;
        repeat (6) @(negedge clk);
        chk(busy == 1'b1, "R1 lone cs_n fall", busy, 1);
        rc_n = 0;
        wait_low(l);
        chk(l == SYNC + 1, "R1 latency rc_n fall", l, SYNC + 1);
        // R7 trace of every trial cycle, R6 requests mid conversion
        tot = 0;
        for (int i = 0; i < BITS * CPB; i++) begin
            k     = BITS - 1 - i / CPB;
            exp_t = (vin & ~((12'(1) << (k + 1)) - 12'(1))) | (12'(1) << k);
            if (k == BITS - 1) exp_t = 12'h800;
            chk(trial_word == exp_t, "R7 trial word", trial_word, exp_t);
            if (i == 5)  chk(result == '0, "R3 result held mid conversion", result, 0);
            if (i == 10) rc_n = 1;
            if (i == 20) rc_n = 0;
            if (i == 30) rc_n = 1;
            tot++;
            @(negedge clk);
        end
        measure_low(n);
        tot += n;
        chk(tot == BUSY_LOW, "R6 busy length with mid request", tot, BUSY_LOW);
        chk(result == 12'hA5C, "R3 result", result, 12'hA5C);
        went_low = 0;
        for (int i = 0; i < 12; i++) begin
            if (!busy) went_low = 1;
            @(negedge clk);
        end
        chk(!went_low, "R4 no restart with select high", went_low, 0);

        // R1 other order: rc_n low first, then cs_n falls
        cs_n = 1;
        repeat (4) @(negedge clk);
        rc_n = 0;
        vin  = 12'h3C1;
        repeat (6) @(negedge clk);
        chk(busy == 1'b1, "R1 lone rc_n fall", busy, 1);
        cs_n = 0;
        wait_low(l);
        chk(l == SYNC + 1, "R1 latency cs_n fall", l, SYNC + 1);
        cs_n = 1;
        measure_low(n);
        chk(n == BUSY_LOW, "R2 busy length", n, BUSY_LOW);
        chk(result == 12'h3C1, "R3 result", result, 12'h3C1);
        repeat (6) @(negedge clk);

        // R5: power-down blocks the request and keeps the result
        pwrdn = 1;
        vin   = 12'h055;
        repeat (4) @(negedge clk);
        cs_n = 0;
        went_low = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!busy) went_low = 1;
        end
        chk(!went_low, "R5 no conversion in power-down", went_low, 0);
        chk(result == 12'h3C1, "R5 result kept", result, 12'h3C1);
        cs_n = 1;
        repeat (4) @(negedge clk);
        pwrdn = 0;
        repeat (4) @(negedge clk);

        // R4/R2/R3 sweep: select held low, conversions back to back
        vin  = 12'd0;
        cs_n = 0;
        wait_low(l);
        chk(l == SYNC + 1, "R1 latency sweep start", l, SYNC + 1);
        for (int v = 0; v <= 4095; v += 3) begin
            measure_low(n);
            chk(n == BUSY_LOW, "R2 busy length sweep", n, BUSY_LOW);
            chk(result == 12'(v), "R3 sweep result", result, v);
            vin = 12'(v + 3);
            @(negedge clk);
            chk(busy == 1'b0, "R4 one-cycle restart", busy, 0);
        end
        cs_n = 1;
        measure_low(n);
        chk(n == BUSY_LOW, "R2 busy length last", n, BUSY_LOW);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule